// File: doc/BRIEF.md
# Four-Channel Block Transfer Engine

The engine moves blocks of byte or 16-bit word elements between one peripheral data register and on-chip SRAM for each of four independent, one-way channels. A channel is armed by a configuration write, then moves one element each time its selected interrupt-source line pulses or software writes its force field. It works as the master of a simple single-cycle bus. One element takes a grant slot, a read cycle and a write cycle. When more than one channel is pending, the lowest channel number always wins the next grant.

Each channel has a peripheral address, two SRAM start addresses, an element count and a control word. The control word selects direction, element size, post-increment, peripheral-indirect addressing, one-shot or auto-repeat, buffer ping-pong, the half-block interrupt and the trigger line. A block-done pulse marks the end of each block. An optional half-block pulse marks its midpoint.

Top module: `dma_quad_engine`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) bus_valid, bus_we, irq_blk and irq_half are 0, and every channel is disabled.
- R2: A channel with control bit 0 (enable) set becomes pending when the line trig_lines[ctrl[15:8]] is high at a clock edge. A request that reaches a disabled channel is ignored: no bus cycle and no interrupt.
- R3: A configuration write to field 5 (force) of an enabled channel makes it pending, in the same way as a trigger line.
- R4: In a cycle with no transfer in progress, the engine grants the pending channel with the lowest number and clears that channel's pending bit. Each element is followed by a new arbitration.
- R5: An element occupies three cycles: the grant cycle (bus idle), a read cycle (bus_valid=1, bus_we=0), then a write cycle (bus_valid=1, bus_we=1). Control bit 1 (direction) at 0 reads the peripheral address and writes the SRAM address. At 1 it reads SRAM and writes the peripheral address.
- R6: Control bit 2 (byte) at 1 drives bus_byte high and writes the read data with bits above bit 7 cleared. At 0 the full 16-bit word is written.
- R7: Control bit 3 (post-increment) at 1 advances the SRAM address by 1 (byte) or 2 (word) after each element. At 0 the address stays fixed.
- R8: Control bit 7 (peripheral-indirect) at 1 replaces the SRAM-side address with the channel's pi_addr slice, sampled in the grant cycle.
- R9: Field 4 holds the element count minus one. irq_blk[c] pulses for one cycle, in the cycle after the write of the element whose index equals that count.
- R10: With control bit 6 set, irq_half[c] pulses for one cycle, in the cycle after the write of element index floor(count/2).
- R11: With control bit 4 (auto-repeat) at 0, the channel clears its enable at block end and discards any pending request. Later requests are ignored.
- R12: With control bit 4 at 1, the channel restarts at index 0. It restarts from start address A (field 2), or, when control bit 5 (ping-pong) is set, from the other buffer's start address (field 3 is buffer B).
- R13: A write to field 0 (control) resets the channel's index to 0, its buffer to A and its address to field 2, and clears its pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_field | input | 3 | Field: 0 control, 1 peripheral address, 2 start A, 3 start B, 4 count, 5 force |
| cfg_wdata | input | 16 | Write data |
| trig_lines | input | 64 | Interrupt-source lines |
| pi_addr | input | 64 | Peripheral-supplied SRAM address, 16 bits per channel |
| bus_valid | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus write (else read) |
| bus_byte | output | 1 | Element is a byte |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid in the read cycle |
| irq_blk | output | 4 | Block-done pulses, one per channel |
| irq_half | output | 4 | Half-block pulses, one per channel |

## Verification
The bench builds the engine with its defaults: four channels, 16-bit addresses and data, a 10-bit count and 64 source lines. With 64 lines, select codes 0x05, 0x0D and 0x20 can drive separate channels. Two channels and a third share line 5 so that all three become pending on the same edge, which exercises arbitration order. Small counts (0, 1, 3, 7) bring block ends, half points and ping-pong swaps within a few dozen cycles.

// File: rtl/dmae_pkg.sv
// Shared encodings of the block transfer engine.
// Assumes the control word is 16 bits wide with the trigger select in its upper byte.
package dmae_pkg;
    localparam int CB_EN   = 0;
    localparam int CB_DIR  = 1;
    localparam int CB_BYTE = 2;
    localparam int CB_INC  = 3;
    localparam int CB_RPT  = 4;
    localparam int CB_PP   = 5;
    localparam int CB_HALF = 6;
    localparam int CB_PIND = 7;
    localparam int SEL_W   = 8;
    localparam int CTRL_W  = 16;
    localparam int FLD_W   = 3;

    typedef enum logic [FLD_W-1:0] {
        F_CTRL  = 3'd0,
        F_PADDR = 3'd1,
        F_BUFA  = 3'd2,
        F_BUFB  = 3'd3,
        F_COUNT = 3'd4,
        F_FORCE = 3'd5
    } fld_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2
    } phase_e;
endpackage

// File: rtl/dmae_chan.sv
// One transfer channel: holds its configuration, latches requests and tracks
// block progress. It raises one-cycle block and half-block pulses.
// Assumes grant and done arrive from the sequencer and are never high together.
module dmae_chan
    import dmae_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 10,
    parameter int NSRC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLD_W-1:0]  wr_field,
    input  logic [AW-1:0]     wr_data,
    input  logic [NSRC-1:0]   lines,
    input  logic              grant,
    input  logic              done,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [AW-1:0]     paddr_o,
    output logic [AW-1:0]     ptr_o,
    output logic              pend_o,
    output logic              irq_blk_o,
    output logic              irq_half_o
);
    logic [CTRL_W-1:0] ctrl;
    logic [AW-1:0]     paddr, bufa, bufb, ptr;
    logic [CW-1:0]     cnt, idx;
    logic              bsel, pend, trig;
    logic              ctrl_wr, force_wr, last, half_pt;
    logic [SEL_W-1:0]  sel;
    logic [AW-1:0]     step;

    assign sel      = ctrl[CTRL_W-1 -: SEL_W];
    assign ctrl_wr  = wr_en && (wr_field == F_CTRL);
    assign force_wr = wr_en && (wr_field == F_FORCE);
    assign last     = (idx == cnt);
    assign half_pt  = (idx == (cnt >> 1));
    assign step     = ctrl[CB_BYTE] ? AW'(1) : AW'(2);

    // Pick the selected trigger line; codes beyond the line count never fire.
    always_comb begin
        trig = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) trig = lines[i];
        end
    end

    // Configuration, request latch and block progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            paddr <= '0;
            bufa  <= '0;
            bufb  <= '0;
            cnt   <= '0;
            idx   <= '0;
            ptr   <= '0;
            bsel  <= 1'b0;
            pend  <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl <= wr_data[CTRL_W-1:0];
            idx  <= '0;
            bsel <= 1'b0;
            ptr  <= bufa;
            pend <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_field)
                    F_PADDR: paddr <= wr_data;
                    F_BUFA:  bufa  <= wr_data;
                    F_BUFB:  bufb  <= wr_data;
                    F_COUNT: cnt   <= wr_data[CW-1:0];
                    default: ;
                endcase
            end
            if (done) begin
                if (last) begin
                    if (ctrl[CB_RPT]) begin
                        idx  <= '0;
                        bsel <= bsel ^ ctrl[CB_PP];
                        ptr  <= (bsel ^ ctrl[CB_PP]) ? bufb : bufa;
                    end else begin
                        ctrl[CB_EN] <= 1'b0;
                    end
                end else begin
                    idx <= idx + CW'(1);
                    if (ctrl[CB_INC]) ptr <= ptr + step;
                end
            end
            if (done && last && !ctrl[CB_RPT]) pend <= 1'b0;
            else pend <= (pend && !grant) || (ctrl[CB_EN] && (trig || force_wr));
        end
    end

    // Interrupt pulses, one cycle after the element's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_blk_o  <= 1'b0;
            irq_half_o <= 1'b0;
        end else begin
            irq_blk_o  <= done && last;
            irq_half_o <= done && ctrl[CB_HALF] && half_pt;
        end
    end

    assign ctrl_o  = ctrl;
    assign paddr_o = paddr;
    assign ptr_o   = ptr;
    assign pend_o  = pend;

    // R2
    disabled_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_EN] |-> !pend);
    // R11
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last && !ctrl[CB_RPT] && !ctrl_wr) |=> (!ctrl[CB_EN] && irq_blk_o));
    // R10
    half_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_half_o |-> ($past(done) && $past(ctrl[CB_HALF])));
endmodule

// File: rtl/dmae_arb.sv
// Fixed-priority arbiter: channel 0 wins over all others.
// Assumes enable is high only in slots where a new element may start.
module dmae_arb #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           enable,
    output logic [NCH-1:0] grant,
    output logic [CHW-1:0] win,
    output logic           any
);
    // Scan from the lowest priority upward so the lowest index is kept last.
    always_comb begin
        grant = '0;
        win   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = enable;
                win      = CHW'(i);
            end
        end
    end

    assign any = enable && (|req);

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    generate
        for (genvar g = 1; g < NCH; g++) begin : g_prio
            // R4
            lower_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant[g] |-> (req[g-1:0] == '0));
        end
    endgenerate
endmodule

// File: rtl/dmae_seq.sv
// Bus sequencer: a granted element gets a read cycle, then a write cycle, then
// the engine arbitrates again. Drives the single-cycle bus from the granted
// channel's configuration.
// Assumes bus_rdata is valid during the read cycle.
module dmae_seq
    import dmae_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        any,
    input  logic [CHW-1:0]              win,
    input  logic [NCH-1:0][CTRL_W-1:0]  ctrl,
    input  logic [NCH-1:0][AW-1:0]      paddr,
    input  logic [NCH-1:0][AW-1:0]      ptr,
    input  logic [NCH-1:0][AW-1:0]      pi_addr,
    input  logic [DW-1:0]               bus_rdata,
    output logic                        idle,
    output logic [NCH-1:0]              done,
    output logic                        bus_valid,
    output logic                        bus_we,
    output logic                        bus_byte,
    output logic [AW-1:0]               bus_addr,
    output logic [DW-1:0]               bus_wdata
);
    phase_e            phase;
    logic [CHW-1:0]    gch;
    logic [AW-1:0]     pil, sram_a;
    logic [DW-1:0]     dat;
    logic [CTRL_W-1:0] gctl;

    // Phase progression and capture of the element in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            gch   <= '0;
            pil   <= '0;
            dat   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (any) begin
                    phase <= PH_RD;
                    gch   <= win;
                    pil   <= pi_addr[win];
                end
                PH_RD: begin
                    dat   <= bus_rdata;
                    phase <= PH_WR;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign idle = (phase == PH_IDLE);
    assign gctl = ctrl[gch];

    // Element-done strobe towards the granted channel.
    always_comb begin
        done = '0;
        if (phase == PH_WR) done[gch] = 1'b1;
    end

    assign sram_a    = gctl[CB_PIND] ? pil : ptr[gch];
    assign bus_valid = (phase != PH_IDLE);
    assign bus_we    = (phase == PH_WR);
    assign bus_byte  = bus_valid && gctl[CB_BYTE];
    assign bus_addr  = !bus_valid ? '0 :
                       (((phase == PH_RD) ^ gctl[CB_DIR]) ? paddr[gch] : sram_a);
    assign bus_wdata = !bus_we ? '0 :
                       (gctl[CB_BYTE] ? {{(DW-8){1'b0}}, dat[7:0]} : dat);

    // R5
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |=> (bus_valid && bus_we));
    // R5
    write_then_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_valid);
    // R5
    write_same_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> $stable(gch));
endmodule

// File: rtl/dma_quad_engine.sv
// Top of the block transfer engine: four channels, a fixed-priority arbiter
// and a bus sequencer.
// Assumes AW >= 16 (control word width) and DW >= 8.
module dma_quad_engine
    import dmae_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int CW   = 10,
    parameter int NSRC = 64,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [FLD_W-1:0]  cfg_field,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic [NSRC-1:0]   trig_lines,
    input  logic [NCH*AW-1:0] pi_addr,
    output logic              bus_valid,
    output logic              bus_we,
    output logic              bus_byte,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    irq_blk,
    output logic [NCH-1:0]    irq_half
);
    logic [NCH-1:0][CTRL_W-1:0] ctrl_v;
    logic [NCH-1:0][AW-1:0]     paddr_v, ptr_v, pi_v;
    logic [NCH-1:0]             pend_v, grant_v, done_v;
    logic [CHW-1:0]             win;
    logic                       any, idle;

    assign pi_v = pi_addr;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            dmae_chan #(.AW(AW), .CW(CW), .NSRC(NSRC)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (cfg_we && (cfg_ch == CHW'(c))),
                .wr_field   (cfg_field),
                .wr_data    (cfg_wdata),
                .lines      (trig_lines),
                .grant      (grant_v[c]),
                .done       (done_v[c]),
                .ctrl_o     (ctrl_v[c]),
                .paddr_o    (paddr_v[c]),
                .ptr_o      (ptr_v[c]),
                .pend_o     (pend_v[c]),
                .irq_blk_o  (irq_blk[c]),
                .irq_half_o (irq_half[c])
            );
        end
    endgenerate

    dmae_arb #(.NCH(NCH)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (pend_v),
        .enable (idle),
        .grant  (grant_v),
        .win    (win),
        .any    (any)
    );

    dmae_seq #(.NCH(NCH), .AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any       (any),
        .win       (win),
        .ctrl      (ctrl_v),
        .paddr     (paddr_v),
        .ptr       (ptr_v),
        .pi_addr   (pi_v),
        .bus_rdata (bus_rdata),
        .idle      (idle),
        .done      (done_v),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_byte  (bus_byte),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    // R9
    blk_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_blk) |-> ($past(bus_we) && !bus_valid));
endmodule

// File: tb/dma_quad_engine_tb.sv
module dma_quad_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_field = '0;
    logic [15:0] cfg_wdata = '0;
    logic [NSRC-1:0] trig_lines = '0;
    logic [63:0] pi_addr;
    logic        bus_valid, bus_we, bus_byte;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic [3:0]  irq_blk, irq_half;

    assign pi_addr   = {16'h4403, 16'h2200, 16'h4401, 16'h4400};
    assign bus_rdata = (bus_addr * 16'd3) ^ 16'h5A17;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_quad_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .trig_lines(trig_lines),
        .pi_addr(pi_addr), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_blk(irq_blk), .irq_half(irq_half)
    );

    int n_chk = 0, n_fail = 0, cycles = 0, n_wr = 0;
    int n_blk[4], n_half[4];
    logic [15:0] wq[$];
    logic [15:0] last_rd;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [15:0] m_ctrl[4], m_pa[4], m_sa[4], m_sb[4], m_ptr[4];
    logic [15:0] m_pil, m_dat;
    int m_cnt[4], m_idx[4], m_ph, m_g;
    bit m_buf[4], m_pend[4];
    logic [3:0] e_blk, e_half;

    function automatic logic [15:0] exp_addr();
        logic [15:0] s;
        s = m_ctrl[m_g][7] ? m_pil : m_ptr[m_g];
        return ((m_ph == 1) ^ m_ctrl[m_g][1]) ? m_pa[m_g] : s;
    endfunction

    always @(posedge clk) begin : model
        int ph, g, sel, win;
        bit gr[4];
        bit wr, cw, frc, trg, newp, dn, lst;
        logic [15:0] a;
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_ctrl[c] = 0; m_pa[c] = 0; m_sa[c] = 0; m_sb[c] = 0; m_ptr[c] = 0;
                m_cnt[c] = 0; m_idx[c] = 0; m_buf[c] = 0; m_pend[c] = 0;
            end
            m_ph = 0; m_g = 0; m_pil = 0; m_dat = 0; e_blk = 0; e_half = 0;
        end else begin
            ph = m_ph; g = m_g; a = exp_addr(); win = -1;
            for (int c = 0; c < 4; c++) gr[c] = 0;
            if (ph == 0) begin
                for (int c = 3; c >= 0; c--) if (m_pend[c]) win = c;
                if (win >= 0) begin
                    gr[win] = 1; m_ph = 1; m_g = win; m_pil = pi_addr[win*16 +: 16];
                end
            end else if (ph == 1) begin
                m_dat = (a * 16'd3) ^ 16'h5A17; m_ph = 2;
            end else m_ph = 0;
            for (int c = 0; c < 4; c++) begin
                wr = cfg_we && (cfg_ch == 2'(c));
                cw = wr && cfg_field == 0;
                frc = wr && cfg_field == 5;
                sel = int'(m_ctrl[c][15:8]);
                trg = (sel < NSRC) ? trig_lines[sel] : 1'b0;
                dn = (ph == 2) && (g == c);
                lst = (m_idx[c] == m_cnt[c]);
                e_blk[c] = dn && lst;
                e_half[c] = dn && m_ctrl[c][6] && (m_idx[c] == m_cnt[c] / 2);
                if (cw) begin
                    m_ctrl[c] = cfg_wdata; m_idx[c] = 0; m_buf[c] = 0;
                    m_ptr[c] = m_sa[c]; m_pend[c] = 0;
                end else begin
                    newp = (m_pend[c] && !gr[c]) || (m_ctrl[c][0] && (trg || frc));
                    if (dn) begin
                        if (lst) begin
                            if (m_ctrl[c][4]) begin
                                m_idx[c] = 0;
                                m_buf[c] = m_buf[c] ^ m_ctrl[c][5];
                                m_ptr[c] = m_buf[c] ? m_sb[c] : m_sa[c];
                            end else begin
                                m_ctrl[c][0] = 0; newp = 0;
                            end
                        end else begin
                            m_idx[c]++;
                            if (m_ctrl[c][3]) m_ptr[c] = m_ptr[c] + (m_ctrl[c][2] ? 16'd1 : 16'd2);
                        end
                    end
                    m_pend[c] = newp;
                    if (wr) begin
                        case (cfg_field)
                            3'd1: m_pa[c] = cfg_wdata;
                            3'd2: m_sa[c] = cfg_wdata;
                            3'd3: m_sb[c] = cfg_wdata;
                            3'd4: m_cnt[c] = int'(cfg_wdata[9:0]);
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin : cmp
        logic [15:0] ew;
        if (rst_n) begin
            chk(bus_valid == (m_ph != 0), "R2 R4 R5", "bus_valid", bus_valid, m_ph != 0);
            chk(bus_we == (m_ph == 2), "R5", "bus_we", bus_we, m_ph == 2);
            if (m_ph != 0) begin
                chk(bus_addr == exp_addr(), "R5 R7 R8 R12 R13", "bus_addr", bus_addr, exp_addr());
                chk(bus_byte == m_ctrl[m_g][2], "R6", "bus_byte", bus_byte, m_ctrl[m_g][2]);
            end
            if (m_ph == 2) begin
                ew = m_ctrl[m_g][2] ? {8'h00, m_dat[7:0]} : m_dat;
                chk(bus_wdata == ew, "R6", "bus_wdata", bus_wdata, ew);
            end
            chk(irq_blk == e_blk, "R9 R11 R12", "irq_blk", irq_blk, e_blk);
            chk(irq_half == e_half, "R10", "irq_half", irq_half, e_half);
            if (bus_we) begin n_wr++; wq.push_back(bus_addr); end
            if (bus_valid && !bus_we) last_rd = bus_addr;
            for (int c = 0; c < 4; c++) begin
                if (irq_blk[c]) n_blk[c]++;
                if (irq_half[c]) n_half[c]++;
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    task automatic wcfg(int ch, int f, int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_field = 3'(f); cfg_wdata = 16'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(int line, int wait_n);
        @(negedge clk); trig_lines[line] = 1'b1;
        @(negedge clk); trig_lines[line] = 1'b0;
        repeat (wait_n) @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin n_blk[c] = 0; n_half[c] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs at rest while and right after reset
        chk(bus_valid == 0 && bus_we == 0, "R1", "bus idle", {bus_valid, bus_we}, 0);
        chk(irq_blk == 0 && irq_half == 0, "R1", "irqs", {irq_blk, irq_half}, 0);
        rst_n = 1'b1;
        pulse(5, 4);
        chk(n_wr == 0, "R1", "no transfer after reset", n_wr, 0);

        // Channel 1: word, post-increment, one-shot, 4 elements on line 13
        wcfg(1, 1, 16'h0300); wcfg(1, 2, 16'h1000); wcfg(1, 4, 3);
        wcfg(1, 0, 16'h0D09);
        for (int k = 0; k < 4; k++) pulse(13, 6);
        chk(n_wr == 4, "R2", "writes from line 13", n_wr, 4);
        chk(n_blk[1] == 1, "R9", "block pulses ch1", n_blk[1], 1);
        chk(wq[3] == 16'h1006, "R7", "last SRAM write ch1", wq[3], 16'h1006);
        pulse(13, 6);
        chk(n_wr == 4, "R11", "request after one-shot end", n_wr, 4);

        // Channel 2 disabled: its request is ignored
        wcfg(2, 0, 16'h0500);
        pulse(5, 6);
        chk(n_wr == 4, "R2", "disabled channel request", n_wr, 4);

        // Channel 3: software force, single element block
        wcfg(3, 1, 16'h0248); wcfg(3, 2, 16'h3000); wcfg(3, 4, 0);
        wcfg(3, 0, 16'h200B);
        wcfg(3, 5, 0);
        repeat (5) @(negedge clk);
        chk(n_wr == 5, "R3", "forced element", n_wr, 5);
        chk(n_blk[3] == 1, "R3", "forced block pulse", n_blk[3], 1);
        chk(wq[4] == 16'h0248, "R5", "SRAM-to-peripheral write addr", wq[4], 16'h0248);
        wcfg(3, 5, 0);
        repeat (5) @(negedge clk);
        chk(n_wr == 5, "R11", "force after one-shot end", n_wr, 5);

        // Three channels on shared line 5
        wcfg(3, 0, 16'h050B);
        wcfg(0, 1, 16'h0226); wcfg(0, 2, 16'h1100); wcfg(0, 3, 16'h1180);
        wcfg(0, 4, 1); wcfg(0, 0, 16'h057F);
        wcfg(2, 1, 16'h0300); wcfg(2, 2, 16'h2000); wcfg(2, 4, 7);
        wcfg(2, 0, 16'h0581);
        pulse(5, 12);
        chk(n_wr == 8, "R4", "three grants", n_wr, 8);
        chk(wq[5] == 16'h0226, "R4", "first grant ch0", wq[5], 16'h0226);
        chk(wq[6] == 16'h2200, "R8", "second grant ch2 indirect", wq[6], 16'h2200);
        chk(wq[7] == 16'h0248, "R4", "third grant ch3", wq[7], 16'h0248);
        for (int k = 0; k < 3; k++) pulse(5, 12);
        chk(n_wr == 14, "R11", "ch3 silent after block", n_wr, 14);
        chk(n_blk[0] == 2, "R12", "ch0 repeats blocks", n_blk[0], 2);
        chk(n_half[0] == 2, "R10", "ch0 half pulses", n_half[0], 2);
        chk(n_blk[3] == 2, "R9", "ch3 block pulses", n_blk[3], 2);
        chk(n_blk[2] == 0, "R9", "ch2 mid-block", n_blk[2], 0);

        // Reinitialise channel 0 mid-block
        pulse(5, 12);
        wcfg(2, 0, 16'h0580);
        wcfg(0, 0, 16'h057F);
        pulse(5, 8);
        chk(last_rd == 16'h1100, "R13", "restart at start A", last_rd, 16'h1100);
        chk(n_half[0] == 4, "R10", "half pulse after restart", n_half[0], 4);
        finish_run();
    end
endmodule